// File: doc/BRIEF.md
# Line-Crossing Load Merge Unit

This block serves byte-addressed loads of 1 to 32 bytes from a small internal data array that holds 64-byte lines. For each load it tests whether the requested bytes lie within a single line or run on into the following line. A load that stays inside one line reads only that line, whatever its alignment. A load that crosses a line edge reads both lines at once on two read paths. It then joins the end of the lower line to the start of the upper line.

Both kinds of load return their result exactly one cycle after the request. The response carries a flag that marks the crossing loads, so a monitor can count the accesses that use both read paths. A plain write port fills whole lines. A request size outside the legal range raises an error pulse and returns no data.

Top module: `split_load_merge`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, rsp_valid, rsp_err and rsp_split are low.
- R2: A legal request (size 1 to 32) gives rsp_valid high in the next cycle, with the same latency whether the load crosses a line or not.
- R3: A load whose bytes all fall in one line, aligned or not, returns in byte i of rsp_data (bits 8i+7:8i) the array byte at address req_addr+i, with rsp_split low.
- R4: A load crosses a line exactly when req_addr[5:0] + req_size > 64. Such a load has rsp_split high. A load ending at byte 63 of a line does not cross.
- R5: For a crossing load, the low bytes of the result are bytes req_addr[5:0]..63 of the lower line, followed by bytes 0 upward of the next line.
- R6: The upper line index is the lower index plus one, modulo the number of lines, so a crossing load from the last line continues in line 0.
- R7: In rsp_data, the bytes at positions req_size and above are zero.
- R8: A request with size 0 or above 32 gives rsp_err high and rsp_valid low in the next cycle, with rsp_data all zero.
- R9: In a cycle after one with req_valid low, rsp_valid and rsp_err are low.
- R10: A line written through the write port is returned by loads issued in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one whole line |
| wr_line | input | IDXW | Index of the line to write |
| wr_data | input | 512 | Line contents, byte 0 in bits 7:0 |
| req_valid | input | 1 | Load request strobe |
| req_addr | input | IDXW+6 | Byte address of the first byte of the load |
| req_size | input | 6 | Number of bytes to load |
| rsp_valid | output | 1 | Load data is valid |
| rsp_data | output | 8*MAXB | Load data, little-endian, right-justified |
| rsp_split | output | 1 | The load crossed a line boundary |
| rsp_err | output | 1 | The request size was illegal |

## Verification
The assertions assume that the line array has been filled before any load reads it. They also assume that a load never reads a line in the same cycle that the line is written. The bench writes every line during setup, and it issues its later rewrite only in cycles with no load. Request size and address otherwise take any value, including the illegal sizes and the crossing cases at the end of the array.

// File: rtl/split_load_merge.sv
module split_load_merge #(
  parameter int IDXW = 4,
  parameter int MAXB = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_line,
  input  logic [511:0]          wr_data,
  input  logic                  req_valid,
  input  logic [IDXW+5:0]       req_addr,
  input  logic [5:0]            req_size,
  output logic                  rsp_valid,
  output logic [8*MAXB-1:0]     rsp_data,
  output logic                  rsp_split,
  output logic                  rsp_err
);
  localparam int LW = 512;
  localparam int OW = 8 * MAXB;
  localparam int AW = IDXW + 6;
  localparam int NL = 1 << IDXW;

  logic [LW-1:0] lines [NL];

  always_ff @(posedge clk)
    if (wr_en) lines[wr_line] <= wr_data;

  logic [5:0]      off;
  logic [IDXW-1:0] lo_idx, hi_idx;
  logic [6:0]      end_pos;
  logic            crosses, legal;
  logic [LW-1:0]   lo_line, hi_line;
  logic [OW-1:0]   keep, picked;

  assign off     = req_addr[5:0];
  assign lo_idx  = req_addr[AW-1:6];
  assign hi_idx  = lo_idx + 1'b1;
  assign end_pos = {1'b0, off} + {1'b0, req_size};
  assign crosses = end_pos > 7'd64;
  assign legal   = (req_size != 6'd0) && (req_size <= 6'(MAXB));

  assign lo_line = lines[lo_idx];
  assign hi_line = crosses ? lines[hi_idx] : '0;

  for (genvar i = 0; i < MAXB; i++) begin : g_keep
    assign keep[i*8 +: 8] = (req_size > 6'(i)) ? 8'hFF : 8'h00;
  end

  assign picked = OW'({hi_line, lo_line} >> {off, 3'b000}) & keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_split <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && legal;
      rsp_split <= req_valid && legal && crosses;
      rsp_err   <= req_valid && !legal;
      rsp_data  <= (req_valid && legal) ? picked : '0;
    end
  end
endmodule

module split_load_merge_chk #(
  parameter int IDXW = 4,
  parameter int MAXB = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [IDXW+5:0]   req_addr,
  input logic [5:0]        req_size,
  input logic              rsp_valid,
  input logic [8*MAXB-1:0] rsp_data,
  input logic              rsp_split,
  input logic              rsp_err
);
  logic ok_size, over_edge;
  assign ok_size   = (req_size >= 6'd1) && (int'(req_size) <= MAXB);
  assign over_edge = (int'(req_addr[5:0]) + int'(req_size)) > 64;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid && !rsp_err && !rsp_split);
  // R2
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ok_size |=> rsp_valid && !rsp_err);
  // R4
  split_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ok_size |=> rsp_split == $past(over_edge));
  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data >> (int'($past(req_size)) * 8)) == '0);
  // R8
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ok_size |=> rsp_err && !rsp_valid && rsp_data == '0);
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_err);
endmodule

bind split_load_merge split_load_merge_chk #(.IDXW(IDXW), .MAXB(MAXB)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_size(req_size), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_split(rsp_split), .rsp_err(rsp_err));

// File: tb/split_load_merge_tb.sv
module split_load_merge_tb_top;
  localparam int IDXW = 4;
  localparam int MAXB = 32;
  localparam int NL = 1 << IDXW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IDXW-1:0] wr_line = '0;
  logic [511:0] wr_data = '0;
  logic req_valid = 1'b0;
  logic [IDXW+5:0] req_addr = '0;
  logic [5:0] req_size = '0;
  logic rsp_valid, rsp_split, rsp_err;
  logic [8*MAXB-1:0] rsp_data;

  int total = 0, bad = 0;
  logic [7:0] model [NL][64];

  always #5 clk = ~clk;

  split_load_merge #(.IDXW(IDXW), .MAXB(MAXB)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fill_line(input int ln, input int seed);
    logic [511:0] d;
    for (int b = 0; b < 64; b++) begin
      model[ln][b] = 8'((ln * 37 + b * 5 + seed) & 255);
      d[b*8 +: 8] = model[ln][b];
    end
    @(negedge clk);
    wr_en = 1'b1; wr_line = IDXW'(ln); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [255:0] expect_data(input logic [IDXW+5:0] a, input int sz);
    logic [255:0] r = '0;
    for (int i = 0; i < sz; i++) begin
      logic [IDXW+5:0] x = a + (IDXW+6)'(i);
      r[i*8 +: 8] = model[x[IDXW+5:6]][x[5:0]];
    end
    return r;
  endfunction

  task automatic load(input logic [IDXW+5:0] a, input int sz, input bit exp_split, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 6'(sz);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1 && rsp_err === 1'b0, {req, " R2 valid"}, 256'(rsp_valid), 256'(1));
    chk(rsp_split === exp_split, {req, " R4 split"}, 256'(rsp_split), 256'(exp_split));
    chk(rsp_data === expect_data(a, sz), {req, " data"}, rsp_data, expect_data(a, sz));
  endtask

  task automatic t_reset;
    chk(!rsp_valid && !rsp_err && !rsp_split, "R1 reset", {rsp_valid, rsp_err, rsp_split}, 0);
  endtask

  task automatic t_inline;
    load({4'd2, 6'd0}, 32, 0, "R3 aligned");
    load({4'd5, 6'd17}, 32, 0, "R3 unaligned");
    load({4'd7, 6'd32}, 32, 0, "R4 ends at byte 63");
  endtask

  task automatic t_cross;
    load({4'd3, 6'd40}, 32, 1, "R5 cross");
    load({4'd9, 6'd63}, 2, 1, "R5 cross one byte");
    load({4'd15, 6'd60}, 16, 1, "R6 wrap");
  endtask

  task automatic t_sizes;
    load({4'd1, 6'd3}, 1, 0, "R7 size1");
    load({4'd6, 6'd61}, 7, 1, "R7 size7 cross");
  endtask

  task automatic t_illegal(input int sz);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {4'd4, 6'd8}; req_size = 6'(sz);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_err === 1'b1 && rsp_valid === 1'b0, "R8 err flag", {rsp_err, rsp_valid}, 256'(2));
    chk(rsp_data === '0, "R8 data zero", rsp_data, 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk(!rsp_valid && !rsp_err, "R9 idle", {rsp_valid, rsp_err}, 0);
  endtask

  task automatic t_rewrite;
    fill_line(3, 101);
    load({4'd3, 6'd10}, 20, 0, "R10 rewrite");
    load({4'd2, 6'd50}, 24, 1, "R10 rewrite cross");
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    for (int l = 0; l < NL; l++) fill_line(l, 11);
    t_inline;
    t_cross;
    t_sizes;
    t_illegal(0);
    t_illegal(33);
    t_idle;
    t_rewrite;
    t_idle;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule